// File: doc/BRIEF.md
# Link Controller Power Mode Sequencer

This block decides which operating mode a serial vehicle-network link controller is in: held in reset, running normally, in a light sleep where its clocks stay on, or in a deep sleep where its clocks are gated off and the line interface drops into low power. The CPU asks for a sleep through a wait strobe or a stop strobe. A configuration bit, called the wait-clock bit here, turns a wait request into a deep sleep. The block returns to normal operation on bus activity. From the light sleep, a correctly received end-of-frame also wakes it.

Each wake-up sets a sticky interrupt flag that the CPU clears with a one-cycle acknowledge. The bus-activity line is asynchronous, so it passes through a two-stage synchronizer, and only a rising edge of the synchronized value counts as activity. After a wake-up from deep sleep the clocks need time to settle. A programmable counter holds the receiver-valid output low for that time, and any end-of-frame seen during it is marked as suspect.

The mode is reported as a two-bit code: 0 reset, 1 run, 2 wait, 3 stop.

Top module: `link_power_seq`

## Requirements
- R1: While rstReq is high, mode is 0 at once, with no clock edge needed, whatever the other inputs do: protoHold=1, wakeIrq=0, clkEn=1, phyLowPwr=0 and rxValid=0.
- R2: On the first rising clock edge after rstReq goes low, mode changes from 0 (reset) to 1 (run).
- R3: In run mode, waitReq=1 with wcmBit=0 and stopReq=0 moves the block to mode 2 (wait) at the next edge, and clkEn stays 1 in wait mode.
- R4: In run mode, stopReq=1, or waitReq=1 with wcmBit=1, moves the block to mode 3 (stop) at the next edge. In stop mode clkEn=0 and phyLowPwr=1. In every other mode clkEn=1 and phyLowPwr=0.
- R5: busActRaw passes through two synchronizing flops. If it rises before edge k while the block is in wait or stop mode, the mode becomes 1 after edge k+2 and not before. Bus activity in run mode changes nothing.
- R6: eofValid=1 in wait mode returns the block to run mode at the next edge. In stop mode eofValid has no effect on the mode.
- R7: A wake-up, whether from wait or from stop, sets wakeIrq at the same edge as the change to run mode. The flag stays set until it is acknowledged.
- R8: irqAck=1 at an edge clears wakeIrq, unless a wake-up happens at that same edge, in which case wakeIrq stays 1.
- R9: waitReq and stopReq have no effect in reset, wait or stop mode.
- R10: A wake-up from stop loads stabCycles into the settle counter. rxValid is then 0 for exactly stabCycles cycles before it returns to 1. Outside that interval, rxValid is 1 in run and wait modes and 0 in reset and stop modes.
- R11: eofSuspect equals eofValid while the block is in run mode with the settle interval still pending, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rstReq | input | 1 | Combined reset request, active high, acts asynchronously |
| waitReq | input | 1 | CPU light-sleep request strobe |
| stopReq | input | 1 | CPU deep-sleep request strobe |
| wcmBit | input | 1 | Wait-clock bit; when set, a wait request enters stop mode |
| busActRaw | input | 1 | Asynchronous bus-activity indication |
| eofValid | input | 1 | Receiver saw a valid end-of-frame |
| irqAck | input | 1 | One-cycle acknowledge that clears the wake flag |
| stabCycles | input | STAB_W | Length of the settle interval after a wake-up from stop |
| mode | output | 2 | Current mode: 0 reset, 1 run, 2 wait, 3 stop |
| clkEn | output | 1 | Enable for the controller's internal clocks |
| phyLowPwr | output | 1 | Puts the line interface into low power |
| protoHold | output | 1 | Holds the protocol logic in reset |
| wakeIrq | output | 1 | Sticky wake-up interrupt request |
| rxValid | output | 1 | Receiver results can be trusted |
| eofSuspect | output | 1 | End-of-frame arrived before the clocks had settled |

## Verification
The assertions check the single-edge mode transitions on every cycle: leaving reset, entering wait or stop, waking on an end-of-frame, and the wait mode refusing requests. They also check that the wake flag stays set until acknowledged, that an acknowledge with no competing wake clears it, and that a wake-up from stop loads the settle counter. Three behaviours can only be shown by the bench's scenarios: the two-flop delay from a raw activity edge to the wake-up, the mode forced to reset in the middle of a cycle by rstReq, and the exact number of cycles rxValid stays low after a wake-up from stop.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RESET = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_WAIT  = 2'd2,
    MODE_STOP  = 2'd3
  } lpmMode_t;

  // Strobes from the mode control to the datapath
  typedef struct packed {
    logic wakeEvt;   // a wake-up happens at this edge
    logic stopWake;  // the wake-up leaves stop mode
    logic rxWindow;  // clocks are on and the protocol logic is released
    logic inRun;     // the block is in run mode
  } lpmStrobe_t;

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstReq,
  input  logic       waitReq,
  input  logic       stopReq,
  input  logic       wcmBit,
  input  logic       eofValid,
  input  logic       actEdge,
  output lpmMode_t   modeQ,
  output lpmStrobe_t strobe,
  output logic       clkEn,
  output logic       phyLowPwr,
  output logic       protoHold
);

  lpmMode_t modeNext;
  logic     goStop;
  logic     goWait;
  logic     wakeNow;

  assign goStop = stopReq | (waitReq & wcmBit);
  assign goWait = waitReq & ~wcmBit;

  always_comb begin
    modeNext = modeQ;
    wakeNow  = 1'b0;
    unique case (modeQ)
      MODE_RESET: modeNext = MODE_RUN;
      MODE_RUN: begin
        if (goStop)      modeNext = MODE_STOP;
        else if (goWait) modeNext = MODE_WAIT;
      end
      MODE_WAIT: begin
        if (actEdge | eofValid) begin
          modeNext = MODE_RUN;
          wakeNow  = 1'b1;
        end
      end
      MODE_STOP: begin
        if (actEdge) begin
          modeNext = MODE_RUN;
          wakeNow  = 1'b1;
        end
      end
      default: modeNext = MODE_RESET;
    endcase
  end

  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq) modeQ <= MODE_RESET;
    else        modeQ <= modeNext;
  end

  assign strobe.wakeEvt  = wakeNow;
  assign strobe.stopWake = wakeNow & (modeQ == MODE_STOP);
  assign strobe.rxWindow = (modeQ == MODE_RUN) | (modeQ == MODE_WAIT);
  assign strobe.inRun    = (modeQ == MODE_RUN);

  assign clkEn     = (modeQ != MODE_STOP);
  assign phyLowPwr = (modeQ == MODE_STOP);
  assign protoHold = (modeQ == MODE_RESET);

  // R2: leaving reset takes exactly one edge
  p_reset_exit_r2: assert property (@(posedge clk) disable iff (rstReq)
    (modeQ == MODE_RESET) |=> (modeQ == MODE_RUN));

  // R3: wait request with the wait-clock bit clear enters wait
  p_wait_enter_r3: assert property (@(posedge clk) disable iff (rstReq)
    (modeQ == MODE_RUN && waitReq && !wcmBit && !stopReq) |=> (modeQ == MODE_WAIT));

  // R4: stop request, or redirected wait request, enters stop
  p_stop_enter_r4: assert property (@(posedge clk) disable iff (rstReq)
    (modeQ == MODE_RUN && (stopReq || (waitReq && wcmBit))) |=> (modeQ == MODE_STOP));

  // R6: end-of-frame wakes from wait
  p_eof_wake_r6: assert property (@(posedge clk) disable iff (rstReq)
    (modeQ == MODE_WAIT && eofValid) |=> (modeQ == MODE_RUN));

  // R9: without a wake cause, wait mode ignores requests
  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rstReq)
    (modeQ == MODE_WAIT && !eofValid && !actEdge) |=> (modeQ == MODE_WAIT));

  // R9: stop mode ignores requests and end-of-frame
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (rstReq)
    (modeQ == MODE_STOP && !actEdge) |=> (modeQ == MODE_STOP));

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_W      = 8
) (
  input  logic              clk,
  input  logic              rstReq,
  input  logic              busActRaw,
  input  logic              irqAck,
  input  logic              eofValid,
  input  logic [STAB_W-1:0] stabCycles,
  input  lpmStrobe_t        strobe,
  output logic              actEdge,
  output logic              wakeIrq,
  output logic              rxValid,
  output logic              eofSuspect
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [STAB_W-1:0]      stabCnt;
  logic                   settling;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or posedge rstReq) begin
        if (rstReq) syncQ[g] <= 1'b0;
        else        syncQ[g] <= busActRaw;
      end
    end else begin : g_rest
      always_ff @(posedge clk or posedge rstReq) begin
        if (rstReq) syncQ[g] <= 1'b0;
        else        syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq) prevQ <= 1'b0;
    else        prevQ <= syncQ[LAST];
  end

  assign actEdge = syncQ[LAST] & ~prevQ;

  // Sticky wake flag; a wake at the same edge beats the acknowledge
  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq)              wakeIrq <= 1'b0;
    else if (strobe.wakeEvt) wakeIrq <= 1'b1;
    else if (irqAck)         wakeIrq <= 1'b0;
  end

  // Settle counter after a wake-up from stop
  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq)               stabCnt <= '0;
    else if (strobe.stopWake) stabCnt <= stabCycles;
    else if (settling)        stabCnt <= stabCnt - 1'b1;
  end

  assign settling   = (stabCnt != '0);
  assign rxValid    = strobe.rxWindow & ~settling;
  assign eofSuspect = eofValid & strobe.inRun & settling;

  // R7: the flag holds until acknowledged
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rstReq)
    (wakeIrq && !irqAck) |=> wakeIrq);

  // R7: a wake event always leaves the flag set
  p_irq_set_r7: assert property (@(posedge clk) disable iff (rstReq)
    strobe.wakeEvt |=> wakeIrq);

  // R8: an acknowledge with no competing wake clears the flag
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (rstReq)
    (irqAck && !strobe.wakeEvt) |=> !wakeIrq);

  // R10: a wake-up from stop loads the programmed settle length
  p_stab_load_r10: assert property (@(posedge clk) disable iff (rstReq)
    strobe.stopWake |=> (stabCnt == $past(stabCycles)));

endmodule

// File: rtl/link_power_seq.sv
module link_power_seq
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_W      = 8
) (
  input  logic              clk,
  input  logic              rstReq,
  input  logic              waitReq,
  input  logic              stopReq,
  input  logic              wcmBit,
  input  logic              busActRaw,
  input  logic              eofValid,
  input  logic              irqAck,
  input  logic [STAB_W-1:0] stabCycles,
  output logic [1:0]        mode,
  output logic              clkEn,
  output logic              phyLowPwr,
  output logic              protoHold,
  output logic              wakeIrq,
  output logic              rxValid,
  output logic              eofSuspect
);

  lpmMode_t   modeQ;
  lpmStrobe_t strobe;
  logic       actEdge;

  lpm_ctrl u_ctrl (
    .clk       (clk),
    .rstReq    (rstReq),
    .waitReq   (waitReq),
    .stopReq   (stopReq),
    .wcmBit    (wcmBit),
    .eofValid  (eofValid),
    .actEdge   (actEdge),
    .modeQ     (modeQ),
    .strobe    (strobe),
    .clkEn     (clkEn),
    .phyLowPwr (phyLowPwr),
    .protoHold (protoHold)
  );

  lpm_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .STAB_W      (STAB_W)
  ) u_dp (
    .clk        (clk),
    .rstReq     (rstReq),
    .busActRaw  (busActRaw),
    .irqAck     (irqAck),
    .eofValid   (eofValid),
    .stabCycles (stabCycles),
    .strobe     (strobe),
    .actEdge    (actEdge),
    .wakeIrq    (wakeIrq),
    .rxValid    (rxValid),
    .eofSuspect (eofSuspect)
  );

  assign mode = modeQ;

endmodule

// File: tb/link_power_seq_tb.sv
`timescale 1ns/1ps
module link_power_seq_tb;

  localparam int STAB_W = 8;

  logic clk = 1'b0;
  logic rstReq = 1'b1;
  logic waitReq = 1'b0, stopReq = 1'b0, wcmBit = 1'b0;
  logic busActRaw = 1'b0, eofValid = 1'b0, irqAck = 1'b0;
  logic [STAB_W-1:0] stabCycles = '0;
  logic [1:0] mode;
  logic clkEn, phyLowPwr, protoHold, wakeIrq, rxValid, eofSuspect;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  // Reference model state
  int mMode = 0;
  bit m1 = 0, m2 = 0, m3 = 0;
  bit mIrq = 0;
  int mCnt = 0;

  always #2.5 clk = ~clk;

  link_power_seq #(.STAB_W(STAB_W)) u_dut (
    .clk(clk), .rstReq(rstReq), .waitReq(waitReq), .stopReq(stopReq),
    .wcmBit(wcmBit), .busActRaw(busActRaw), .eofValid(eofValid),
    .irqAck(irqAck), .stabCycles(stabCycles), .mode(mode), .clkEn(clkEn),
    .phyLowPwr(phyLowPwr), .protoHold(protoHold), .wakeIrq(wakeIrq),
    .rxValid(rxValid), .eofSuspect(eofSuspect)
  );

  function automatic bit expClkEn(int m);   return m != 3; endfunction
  function automatic bit expPhyLow(int m);  return m == 3; endfunction
  function automatic bit expHold(int m);    return m == 0; endfunction
  function automatic bit expRxValid(int m, int c);
    return (m == 1 || m == 2) && c == 0;
  endfunction
  function automatic bit expSuspect(int m, int c, bit e);
    return e && m == 1 && c != 0;
  endfunction

  task automatic modelReset();
    mMode = 0; m1 = 0; m2 = 0; m3 = 0; mIrq = 0; mCnt = 0;
  endtask

  task automatic modelEdge();
    bit edgeSeen, wake, sWake;
    int nxt;
    edgeSeen = m2 && !m3;
    wake = 0; sWake = 0; nxt = mMode;
    case (mMode)
      0: nxt = 1;
      1: if (stopReq || (waitReq && wcmBit)) nxt = 3;
         else if (waitReq) nxt = 2;
      2: if (edgeSeen || eofValid) begin nxt = 1; wake = 1; end
      3: if (edgeSeen) begin nxt = 1; wake = 1; sWake = 1; end
      default: nxt = 0;
    endcase
    if (wake) mIrq = 1; else if (irqAck) mIrq = 0;
    if (sWake) mCnt = int'(stabCycles); else if (mCnt != 0) mCnt = mCnt - 1;
    mMode = nxt;
    m3 = m2; m2 = m1; m1 = busActRaw;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag,   "mode",       int'(mode),       mMode);
    chk("R4",  "clkEn",      int'(clkEn),      int'(expClkEn(mMode)));
    chk("R4",  "phyLowPwr",  int'(phyLowPwr),  int'(expPhyLow(mMode)));
    chk("R1",  "protoHold",  int'(protoHold),  int'(expHold(mMode)));
    chk("R7",  "wakeIrq",    int'(wakeIrq),    int'(mIrq));
    chk("R10", "rxValid",    int'(rxValid),    int'(expRxValid(mMode, mCnt)));
    chk("R11", "eofSuspect", int'(eofSuspect), int'(expSuspect(mMode, mCnt, eofValid)));
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    if (!rstReq) modelEdge();
    #1;
    checkAll(tag);
  endtask

  task automatic clearIn();
    @(negedge clk);
    waitReq = 0; stopReq = 0; eofValid = 0; irqAck = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    modelReset();
    // R1: reset values with noisy inputs
    @(negedge clk);
    waitReq = 1; stopReq = 1; eofValid = 1; busActRaw = 1; irqAck = 1;
    tick("R1"); tick("R1");
    chk("R1", "mode literal", int'(mode), 0);
    chk("R1", "rxValid literal", int'(rxValid), 0);
    @(negedge clk);
    waitReq = 0; stopReq = 0; eofValid = 0; busActRaw = 0; irqAck = 0;
    tick("R1"); tick("R1");
    // R2: release
    @(negedge clk); rstReq = 0;
    tick("R2");
    chk("R2", "mode literal", int'(mode), 1);
    // R5: activity in run does nothing
    @(negedge clk); busActRaw = 1;
    tick("R5"); tick("R5"); tick("R5"); tick("R5");
    chk("R5", "mode in run", int'(mode), 1);
    @(negedge clk); busActRaw = 0;
    tick("R5"); tick("R5"); tick("R5");
    // R3: enter wait
    @(negedge clk); waitReq = 1; wcmBit = 0;
    tick("R3");
    chk("R3", "mode literal", int'(mode), 2);
    chk("R3", "clkEn in wait", int'(clkEn), 1);
    // R9: stop request in wait ignored
    @(negedge clk); waitReq = 0; stopReq = 1;
    tick("R9");
    chk("R9", "mode stays wait", int'(mode), 2);
    // R6, R7: end-of-frame wakes from wait
    @(negedge clk); stopReq = 0; eofValid = 1;
    tick("R6");
    chk("R6", "mode literal", int'(mode), 1);
    chk("R7", "wakeIrq literal", int'(wakeIrq), 1);
    clearIn(); tick("R7"); tick("R7");
    chk("R7", "wakeIrq sticky", int'(wakeIrq), 1);
    // R8: acknowledge clears
    @(negedge clk); irqAck = 1;
    tick("R8");
    chk("R8", "wakeIrq cleared", int'(wakeIrq), 0);
    // R4: stop request
    @(negedge clk); irqAck = 0; stopReq = 1;
    tick("R4");
    chk("R4", "mode literal", int'(mode), 3);
    chk("R4", "clkEn off", int'(clkEn), 0);
    // R6: eof in stop ignored; R9: wait request in stop ignored
    @(negedge clk); stopReq = 0; eofValid = 1; waitReq = 1;
    tick("R6");
    chk("R6", "mode stays stop", int'(mode), 3);
    // R5, R10: wake from stop with a settle length of 3
    @(negedge clk); eofValid = 0; waitReq = 0; stabCycles = 8'd3; busActRaw = 1;
    tick("R5");
    chk("R5", "stop after k", int'(mode), 3);
    tick("R5");
    chk("R5", "stop after k+1", int'(mode), 3);
    tick("R5");
    chk("R5", "run after k+2", int'(mode), 1);
    chk("R10", "rxValid low 1", int'(rxValid), 0);
    @(negedge clk); eofValid = 1;
    #1 chk("R11", "eofSuspect literal", int'(eofSuspect), 1);
    tick("R10");
    chk("R10", "rxValid low 2", int'(rxValid), 0);
    @(negedge clk); eofValid = 0;
    tick("R10");
    chk("R10", "rxValid low 3", int'(rxValid), 0);
    tick("R10");
    chk("R10", "rxValid back", int'(rxValid), 1);
    @(negedge clk); busActRaw = 0; irqAck = 1;
    tick("R8");
    // R4: redirected wait
    @(negedge clk); irqAck = 0; waitReq = 1; wcmBit = 1;
    tick("R4");
    chk("R4", "redirect to stop", int'(mode), 3);
    clearIn(); tick("R4");
    // R1: reset in the middle of stop takes effect without an edge
    @(negedge clk); rstReq = 1; modelReset();
    #1 checkAll("R1");
    chk("R1", "async mode", int'(mode), 0);
    @(negedge clk); rstReq = 0; wcmBit = 0;
    tick("R2");
    // R8: acknowledge with a same-edge wake
    @(negedge clk); waitReq = 1;
    tick("R3");
    @(negedge clk); waitReq = 0; eofValid = 1; irqAck = 1;
    tick("R8");
    chk("R8", "ack loses to wake", int'(wakeIrq), 1);
    clearIn(); tick("R8");

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rstReq   = ($urandom_range(0, 99) < 2);
      waitReq  = ($urandom_range(0, 7) == 0);
      stopReq  = ($urandom_range(0, 9) == 0);
      wcmBit   = ($urandom_range(0, 3) == 0);
      eofValid = ($urandom_range(0, 7) == 0);
      irqAck   = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 5) == 0) busActRaw = ~busActRaw;
      if ($urandom_range(0, 49) == 0) stabCycles = STAB_W'($urandom_range(0, 7));
      if (rstReq) begin
        modelReset();
        #1 checkAll("R1");
      end
      tick("R9");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule